// File: doc/BRIEF.md
# Paged Data Address Translator with Counted Page Override

This block turns a 16-bit logical data address into a 24-bit physical address. Four page pointer registers each hold a 10-bit page number. The two top bits of the logical address pick one of the four pointers. The low 14 bits are carried over unchanged as the offset inside a 16 KB page. With the four pointers, 64 KB of data can be reached at any time without reloading a register.

A page-extension command gives a page number and an instruction count. For the next 1 to 4 completed instructions, every data access uses that page, whatever the top address bits are. The pointer registers are not touched during this time. Each instruction-complete strobe consumes one unit of the count, whether or not the instruction accessed data. When the count runs out, translation goes back to the pointer registers.

The translation is combinational by default. A parameter selects a registered output stage instead.

Top module: `dpage_xlate`

## Requirements
- R1: While reset is held and right after it, pointer register i holds page i and no override is active, so the physical address is the logical address extended with zeros.
- R2: With no override active, `phys_addr` = {pointer[`log_addr[15:14]`], `log_addr[13:0]`}.
- R3: When `ptr_we` is high, `ptr_wdata` is written into the pointer selected by `ptr_idx` (0 to 3). The new value is used from the next cycle. Pointers that are not written keep their values.
- R4: When `ovr_start` is high and `ovr_count` is 1 to 4, `ovr_active` goes high in the next cycle. While it is high, `phys_addr` = {`ovr_page` captured at start, `log_addr[13:0]`}, for any value of `log_addr[15:14]`. A count of 5 to 7 acts as 4. A count of 0 makes the start have no effect.
- R5: Each `instr_done` pulse while an override is active uses up one count. This holds whether or not the instruction accessed data. A pulse in the same cycle as an accepted start is not counted. After the last count is used, `ovr_active` is low in the next cycle and R2 translation applies again.
- R6: A pointer write made while an override is active updates the register. It does not change the page used by accesses under the override. The new value shows up once the override has expired.
- R7: An accepted start while an override is already active reloads both the page and the count from the new command.
- R8: `ovr_active` is high exactly while override counts remain. Without an accepted start it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Pointer register write enable |
| ptr_idx | input | 2 | Index of the pointer register to write |
| ptr_wdata | input | 10 | Page number to write |
| ovr_start | input | 1 | Page-extension command strobe |
| ovr_page | input | 10 | Override page number |
| ovr_count | input | 3 | Number of instructions covered (1 to 4) |
| instr_done | input | 1 | Instruction-complete strobe |
| log_addr | input | 16 | Logical data address |
| phys_addr | output | 24 | Physical data address |
| ovr_active | output | 1 | High while override counts remain |

## Verification
The hardest cases to reach from the ports are events that coincide with the override window. These are a pointer write that lands inside the window, a restart issued while counts remain, and an instruction strobe in the very cycle a start is accepted. Directed sequences set up each of these on purpose. Long runs of random stimulus then mix frequent starts (including counts of 0 and above 4), strobes and pointer writes, so that these overlaps happen many more times. Every cycle is compared with a reference model kept in the bench.

// File: rtl/dpage_pkg.sv
package dpage_pkg;

   typedef enum logic {
      SRC_POINTER  = 1'b0,
      SRC_OVERRIDE = 1'b1
   } page_src_e;

   // Clamp a requested override length to the supported maximum.
   function automatic int unsigned clamp_count(input int unsigned req, input int unsigned lim);
      return (req > lim) ? lim : req;
   endfunction

endpackage

// File: rtl/dpage_ptr_bank.sv
module dpage_ptr_bank #(
   parameter int NPTR  = 4,
   parameter int PG_W  = 10,
   parameter int SEL_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [SEL_W-1:0]           idx,
   input  logic [PG_W-1:0]            wdata,
   output logic [NPTR-1:0][PG_W-1:0]  ptr_q
);

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic [PG_W-1:0] reg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_q <= PG_W'(g);
         end else if (we && (idx == SEL_W'(g))) begin
            reg_q <= wdata;
         end
      end

      assign ptr_q[g] = reg_q;
   end

endmodule

// File: rtl/dpage_ovr_ctrl.sv
module dpage_ovr_ctrl
   import dpage_pkg::*;
#(
   parameter int PG_W    = 10,
   parameter int CNT_MAX = 4,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PG_W-1:0]  page_in,
   input  logic [CNT_W-1:0] count_in,
   input  logic             instr_done,
   output logic             active,
   output logic [PG_W-1:0]  page_q,
   output logic [CNT_W-1:0] remain_q
);

   logic             start_ok;
   logic [CNT_W-1:0] load_val;

   assign start_ok = start && (count_in != '0);
   assign load_val = CNT_W'(clamp_count(int'(count_in), CNT_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         page_q   <= '0;
      end else if (start_ok) begin
         remain_q <= load_val;
         page_q   <= page_in;
      end else if ((remain_q != '0) && instr_done) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign active = (remain_q != '0);

endmodule

// File: rtl/dpage_addr_form.sv
module dpage_addr_form
   import dpage_pkg::*;
#(
   parameter int NPTR  = 4,
   parameter int PG_W  = 10,
   parameter int OFS_W = 14,
   parameter int SEL_W = 2
) (
   input  logic [OFS_W+SEL_W-1:0]     log_addr,
   input  logic [NPTR-1:0][PG_W-1:0]  ptr_q,
   input  logic                       ovr_on,
   input  logic [PG_W-1:0]            ovr_page,
   output logic [PG_W+OFS_W-1:0]      phys
);

   logic [SEL_W-1:0] sel;
   logic [OFS_W-1:0] offset;
   page_src_e        src;
   logic [PG_W-1:0]  page;

   assign sel    = log_addr[OFS_W+SEL_W-1:OFS_W];
   assign offset = log_addr[OFS_W-1:0];
   assign src    = ovr_on ? SRC_OVERRIDE : SRC_POINTER;

   always_comb begin
      unique case (src)
         SRC_OVERRIDE: page = ovr_page;
         default:      page = ptr_q[sel];
      endcase
   end

   assign phys = {page, offset};

endmodule

// File: rtl/dpage_xlate.sv
module dpage_xlate #(
   parameter int NPTR    = 4,
   parameter int PG_W    = 10,
   parameter int OFS_W   = 14,
   parameter int CNT_MAX = 4,
   parameter bit REG_OUT = 1'b0,
   localparam int SEL_W  = $clog2(NPTR),
   localparam int LA_W   = OFS_W + SEL_W,
   localparam int PA_W   = PG_W + OFS_W,
   localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_we,
   input  logic [SEL_W-1:0]  ptr_idx,
   input  logic [PG_W-1:0]   ptr_wdata,
   input  logic              ovr_start,
   input  logic [PG_W-1:0]   ovr_page,
   input  logic [CNT_W-1:0]  ovr_count,
   input  logic              instr_done,
   input  logic [LA_W-1:0]   log_addr,
   output logic [PA_W-1:0]   phys_addr,
   output logic              ovr_active
);

   if ((NPTR < 2) || ((1 << SEL_W) != NPTR)) begin : g_bad_nptr
      $error("NPTR must be a power of two of at least 2");
   end
   if (CNT_MAX < 1) begin : g_bad_cnt
      $error("CNT_MAX must be at least 1");
   end
   if ((PG_W < 1) || (OFS_W < 1)) begin : g_bad_width
      $error("page and offset widths must be positive");
   end

   logic [NPTR-1:0][PG_W-1:0] ptr_q;
   logic [PG_W-1:0]           ovr_page_q;
   logic [CNT_W-1:0]          remain_q;
   logic                      ovr_on;
   logic [PA_W-1:0]           phys_comb;

   dpage_ptr_bank #(
      .NPTR (NPTR),
      .PG_W (PG_W),
      .SEL_W(SEL_W)
   ) ptr_bank_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (ptr_we),
      .idx  (ptr_idx),
      .wdata(ptr_wdata),
      .ptr_q(ptr_q)
   );

   dpage_ovr_ctrl #(
      .PG_W   (PG_W),
      .CNT_MAX(CNT_MAX),
      .CNT_W  (CNT_W)
   ) ovr_ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ovr_start),
      .page_in   (ovr_page),
      .count_in  (ovr_count),
      .instr_done(instr_done),
      .active    (ovr_on),
      .page_q    (ovr_page_q),
      .remain_q  (remain_q)
   );

   dpage_addr_form #(
      .NPTR (NPTR),
      .PG_W (PG_W),
      .OFS_W(OFS_W),
      .SEL_W(SEL_W)
   ) addr_form_i (
      .log_addr(log_addr),
      .ptr_q   (ptr_q),
      .ovr_on  (ovr_on),
      .ovr_page(ovr_page_q),
      .phys    (phys_comb)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phys_addr <= '0;
         end else begin
            phys_addr <= phys_comb;
         end
      end
   end else begin : g_comb_out
      assign phys_addr = phys_comb;
   end

   assign ovr_active = ovr_on;

endmodule

// File: rtl/dpage_xlate_chk.sv
module dpage_xlate_chk #(
   parameter int NPTR    = 4,
   parameter int PG_W    = 10,
   parameter int OFS_W   = 14,
   parameter int CNT_MAX = 4,
   parameter bit REG_OUT = 1'b0,
   parameter int CNT_W   = 3,
   parameter int PA_W    = 24
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ptr_we,
   input logic                      ovr_start,
   input logic [CNT_W-1:0]          ovr_count,
   input logic                      instr_done,
   input logic                      ovr_active,
   input logic [PA_W-1:0]           phys_addr,
   input logic [CNT_W-1:0]          remain_q,
   input logic [NPTR-1:0][PG_W-1:0] ptr_q
);

   logic accepted;
   assign accepted = ovr_start && (ovr_count != '0);

   AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      remain_q <= CNT_W'(CNT_MAX)); // R5

   AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> ovr_active); // R4

   AST_LAST_COUNT_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_q == CNT_W'(1) && instr_done && !accepted) |=> !ovr_active); // R5

   AST_NO_SPONTANEOUS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_active && !accepted) |=> !ovr_active); // R8

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_we |=> $stable(ptr_q)); // R3

   if (!REG_OUT) begin : g_comb_chk
      AST_OVR_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
         (ovr_active && $past(ovr_active) && !$past(ovr_start))
         |-> (phys_addr[PA_W-1:OFS_W] == $past(phys_addr[PA_W-1:OFS_W]))); // R6
   end

endmodule

bind dpage_xlate dpage_xlate_chk #(
   .NPTR   (NPTR),
   .PG_W   (PG_W),
   .OFS_W  (OFS_W),
   .CNT_MAX(CNT_MAX),
   .REG_OUT(REG_OUT),
   .CNT_W  (CNT_W),
   .PA_W   (PA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr_we    (ptr_we),
   .ovr_start (ovr_start),
   .ovr_count (ovr_count),
   .instr_done(instr_done),
   .ovr_active(ovr_active),
   .phys_addr (phys_addr),
   .remain_q  (remain_q),
   .ptr_q     (ptr_q)
);

// File: tb/dpage_xlate_tb_top.sv
module dpage_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_we = 1'b0;
   logic [1:0]  ptr_idx = '0;
   logic [9:0]  ptr_wdata = '0;
   logic        ovr_start = 1'b0;
   logic [9:0]  ovr_page = '0;
   logic [2:0]  ovr_count = '0;
   logic        instr_done = 1'b0;
   logic [15:0] log_addr = '0;
   logic [23:0] phys_addr;
   logic        ovr_active;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // reference model state
   logic [9:0] m_ptr [4];
   int         m_rem;
   logic [9:0] m_pg;

   always #10 clk = ~clk;

   dpage_xlate dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_we    (ptr_we),
      .ptr_idx   (ptr_idx),
      .ptr_wdata (ptr_wdata),
      .ovr_start (ovr_start),
      .ovr_page  (ovr_page),
      .ovr_count (ovr_count),
      .instr_done(instr_done),
      .log_addr  (log_addr),
      .phys_addr (phys_addr),
      .ovr_active(ovr_active)
   );

   function automatic logic [23:0] exp_phys(input logic [15:0] la);
      if (m_rem != 0) return {m_pg, la[13:0]};
      return {m_ptr[la[15:14]], la[13:0]};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [1:0] idx, input logic [9:0] wd,
                        input logic st, input logic [9:0] pg, input logic [2:0] cnt,
                        input logic dn, input logic [15:0] la);
      ptr_we = we; ptr_idx = idx; ptr_wdata = wd;
      ovr_start = st; ovr_page = pg; ovr_count = cnt;
      instr_done = dn; log_addr = la;
   endtask

   // check the current cycle, advance the model, move to the next low phase
   task automatic cyc(input string req);
      #2;
      chk(req, "phys_addr", 32'(phys_addr), 32'(exp_phys(log_addr)));
      chk(req, "ovr_active", 32'(ovr_active), 32'(m_rem != 0));
      if (ovr_start && ovr_count != 0) begin
         m_rem = (ovr_count > 4) ? 4 : int'(ovr_count);
         m_pg  = ovr_page;
      end else if (m_rem != 0 && instr_done) begin
         m_rem--;
      end
      if (ptr_we) m_ptr[ptr_idx] = ptr_wdata;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) m_ptr[i] = 10'(i);
      m_rem = 0;
      m_pg  = '0;

      // R1: reset state, identity mapping
      repeat (3) @(negedge clk);
      drive(0, 0, 0, 0, 0, 0, 0, 16'h1234);
      #2;
      chk("R1", "phys in reset", 32'(phys_addr), 32'h001234);
      chk("R1", "flag in reset", 32'(ovr_active), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, 0, 0, 16'hC001);
      cyc("R1");
      chk("R1", "identity C001", 32'(phys_addr), 32'h00C001);

      // R3: write pointer 1, seen next cycle
      drive(1, 2'd1, 10'h155, 0, 0, 0, 0, 16'h4010);
      cyc("R3");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h4010);
      cyc("R3");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h8010);
      cyc("R2");

      // R4/R5: start with count 2, strobe in start cycle ignored
      drive(0, 0, 0, 1, 10'h2AB, 3'd2, 1, 16'h4005);
      cyc("R5");
      drive(0, 0, 0, 0, 0, 0, 0, 16'hC005);
      cyc("R4");
      chk("R4", "override page", 32'(phys_addr[23:14]), 32'h2AB);
      drive(0, 0, 0, 0, 0, 0, 1, 16'h0007);
      cyc("R5");
      drive(0, 0, 0, 0, 0, 0, 1, 16'h8007);
      cyc("R5");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h4007);
      cyc("R5");
      chk("R5", "back to pointer", 32'(phys_addr), 32'h554007);

      // R4: count 0 ignored
      drive(0, 0, 0, 1, 10'h3FF, 3'd0, 0, 16'h0001);
      cyc("R4");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h0001);
      cyc("R4");
      chk("R4", "count zero flag", 32'(ovr_active), 32'd0);

      // R4: count 7 acts as 4
      drive(0, 0, 0, 1, 10'h011, 3'd7, 0, 16'h0000);
      cyc("R4");
      for (int k = 0; k < 3; k++) begin
         drive(0, 0, 0, 0, 0, 0, 1, 16'hFFFF);
         cyc("R4");
      end
      chk("R4", "saturated still active", 32'(ovr_active), 32'd1);

      // R6: pointer write during override
      drive(1, 2'd2, 10'h0F0, 0, 0, 0, 0, 16'h8020);
      cyc("R6");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h8020);
      cyc("R6");
      chk("R6", "override unaffected", 32'(phys_addr), {8'h0, 10'h011, 14'h0020});
      drive(0, 0, 0, 0, 0, 0, 1, 16'h8020);
      cyc("R6");
      drive(0, 0, 0, 0, 0, 0, 0, 16'h8020);
      cyc("R6");
      chk("R6", "new pointer after expiry", 32'(phys_addr), {8'h0, 10'h0F0, 14'h0020});

      // R7: restart while active
      drive(0, 0, 0, 1, 10'h100, 3'd1, 0, 16'h0100);
      cyc("R7");
      drive(0, 0, 0, 1, 10'h200, 3'd3, 1, 16'h0100);
      cyc("R7");
      drive(0, 0, 0, 0, 0, 0, 1, 16'h0100);
      cyc("R7");
      chk("R7", "reloaded page", 32'(phys_addr[23:14]), 32'h200);
      drive(0, 0, 0, 0, 0, 0, 1, 16'h0100);
      cyc("R7");
      drive(0, 0, 0, 0, 0, 0, 1, 16'h0100);
      cyc("R7");
      chk("R8", "flag low after reload expiry", 32'(ovr_active), 32'd0);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         drive(($urandom % 6) == 0, 2'($urandom), 10'($urandom),
               ($urandom % 8) == 0, 10'($urandom), 3'($urandom),
               1'($urandom), 16'($urandom));
         cyc((m_rem != 0) ? "R4" : "R2");
      end

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule